// File: doc/BRIEF.md
# Pipeline Hazard Control Unit

This block decides, cycle by cycle, which pipeline registers of a five-stage in-order load/store pipeline (fetch, decode, execute, memory, writeback) may load, which must be emptied, and whether the program counter advances or is redirected. The block is combinational. It reads a short descriptor for the instruction sitting in each of the decode, execute, memory and writeback stages. It drives a write enable and a synchronous clear for each of the four pipeline registers (IF/ID, ID/EX, EX/MEM, MEM/WB), a program-counter write enable, and a redirect strobe.

It resolves three conflicts. The first is a read-after-write dependence. There is no forwarding, so a decode-stage instruction that reads a register still being produced by an older instruction waits in decode, and bubbles go into execute. The second is the single memory port shared by instruction fetch and data access. A load or store in the memory stage takes that port, so no fetch happens in that cycle. The third is a taken branch, which is known in execute. It squashes the two younger instructions and redirects the program counter, so each taken branch costs two cycles.

Register fields are taken from the raw instruction words: rs from bits 25:21, rt from bits 20:16, rd from bits 15:11.

Top module: `pipe_hazard_unit`

## Requirements
- R1: With every stage invalid, the outputs are pcWrite=1, pcRedirect=0, all four write enables 1 and all four clears 0.
- R2: A valid decode instruction that uses rs (bits 25:21) or rt (bits 20:16) matching the destination of a valid, register-writing execute-stage instruction causes a RAW stall: pcWrite=0, ifIdWrite=0, ifIdClear=0, idExClear=1.
- R3: The same RAW stall results when the matching writer is in the memory stage.
- R4: A writer's destination is rd (bits 15:11) when its destRd flag is 1, and rt (bits 20:16) when it is 0.
- R5: A destination of register 0 never creates a dependence.
- R6: With SPLIT_RF=1 (the default), a writer in writeback never stalls decode. With SPLIT_RF=0, it stalls exactly like R2.
- R7: No stall arises from a source whose use flag is 0, from a writer with regWrite=0 or valid=0, or from an invalid decode stage.
- R8: A valid memory-stage instruction with memAccess=1 and no RAW stall blocks the fetch: pcWrite=0, ifIdWrite=1, ifIdClear=1, idExClear=0.
- R9: A RAW stall and a busy memory port in the same cycle give the RAW stall outputs of R2.
- R10: A valid execute-stage instruction with branchTaken=1 gives pcWrite=1, pcRedirect=1, ifIdClear=1 and idExClear=1, whatever RAW or port conditions also hold.
- R11: The EX/MEM and MEM/WB registers always load (write=1, clear=0), so older instructions always advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| idValid | input | 1 | Decode stage holds an instruction |
| idInstr | input | 32 | Decode-stage instruction word |
| idUseRs | input | 1 | Decode instruction reads rs |
| idUseRt | input | 1 | Decode instruction reads rt |
| exValid | input | 1 | Execute stage holds an instruction |
| exInstr | input | 32 | Execute-stage instruction word |
| exRegWrite | input | 1 | Execute instruction writes a register |
| exDestRd | input | 1 | Execute destination is rd (1) or rt (0) |
| exBranchTaken | input | 1 | Execute instruction is a taken branch |
| memValid | input | 1 | Memory stage holds an instruction |
| memInstr | input | 32 | Memory-stage instruction word |
| memRegWrite | input | 1 | Memory instruction writes a register |
| memDestRd | input | 1 | Memory destination is rd (1) or rt (0) |
| memAccess | input | 1 | Memory instruction is a load or store |
| wbValid | input | 1 | Writeback stage holds an instruction |
| wbInstr | input | 32 | Writeback-stage instruction word |
| wbRegWrite | input | 1 | Writeback instruction writes a register |
| wbDestRd | input | 1 | Writeback destination is rd (1) or rt (0) |
| pcWrite | output | 1 | Program counter loads |
| pcRedirect | output | 1 | Program counter loads the branch target |
| ifIdWrite | output | 1 | IF/ID register write enable |
| ifIdClear | output | 1 | IF/ID register synchronous clear |
| idExWrite | output | 1 | ID/EX register write enable |
| idExClear | output | 1 | ID/EX register synchronous clear |
| exMemWrite | output | 1 | EX/MEM register write enable |
| exMemClear | output | 1 | EX/MEM register synchronous clear |
| memWbWrite | output | 1 | MEM/WB register write enable |
| memWbClear | output | 1 | MEM/WB register synchronous clear |

## Verification
The bench targets the destination-field choice by placing a source match only in rt or only in rd of a writer. A unit that picks the wrong field would stall when it should not, or miss a real dependence. Other cases: register 0 as the destination, where a careless comparator stalls forever on writes to the zero register; a writeback-stage writer under both settings of SPLIT_RF; and every overlap of branch, RAW and port conflicts. Wrong priority there would either freeze a decode instruction that is about to be squashed, or let a fetch go through while the memory port is busy. An exhaustive sweep of source against destination indices catches comparator width or bit-slice errors.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  parameter int unsigned INSTR_W = 32;
  parameter int unsigned REG_W   = 5;
  parameter int unsigned RS_LSB  = 21;
  parameter int unsigned RT_LSB  = 16;
  parameter int unsigned RD_LSB  = 11;

  // Descriptor of an older, possibly register-writing stage.
  typedef struct packed {
    logic               valid;
    logic [INSTR_W-1:0] instr;
    logic               regWrite;
    logic               destRd;
  } writerDesc_t;

  // Strobes passed from the matching datapath to the control.
  typedef struct packed {
    logic rawHit;
    logic portBusy;
    logic redirect;
  } hazardStrobes_t;

  // Per-register enables and clears.
  typedef struct packed {
    logic pcWrite;
    logic pcRedirect;
    logic ifIdWrite;
    logic ifIdClear;
    logic idExWrite;
    logic idExClear;
    logic exMemWrite;
    logic exMemClear;
    logic memWbWrite;
    logic memWbClear;
  } stageCtl_t;
endpackage

// File: rtl/hazard_datapath.sv
module hazard_datapath
  import hazard_pkg::*;
#(
  parameter bit          SPLIT_RF = 1'b1,
  parameter int unsigned NUM_WR   = 3
) (
  input  logic                      idValid,
  input  logic [INSTR_W-1:0]        idInstr,
  input  logic                      idUseRs,
  input  logic                      idUseRt,
  input  writerDesc_t [NUM_WR-1:0]  writers,
  input  logic                      exValid,
  input  logic                      exBranchTaken,
  input  logic                      memValid,
  input  logic                      memAccess,
  output hazardStrobes_t            strobes
);
  // The youngest writer is index 0 (EX); the oldest is NUM_WR-1 (WB).
  localparam int LAST_STALL = SPLIT_RF ? int'(NUM_WR) - 2 : int'(NUM_WR) - 1;

  logic [REG_W-1:0]  srcRs, srcRt;
  logic [NUM_WR-1:0] wrHit;
  logic [REG_W-1:0]  wrDest [NUM_WR];

  assign srcRs = idInstr[RS_LSB +: REG_W];
  assign srcRt = idInstr[RT_LSB +: REG_W];

  logic unusedIdBits;
  assign unusedIdBits = ^{idInstr[INSTR_W-1:RS_LSB+REG_W], idInstr[RT_LSB-1:0]};

  for (genvar i = 0; i < NUM_WR; i++) begin : g_writer
    localparam bit STALL_EN = (i <= LAST_STALL);
    logic live, matchRs, matchRt;
    logic unusedWrBits;

    assign wrDest[i] = writers[i].destRd ? writers[i].instr[RD_LSB +: REG_W]
                                         : writers[i].instr[RT_LSB +: REG_W];
    assign unusedWrBits = ^{writers[i].instr[INSTR_W-1:RS_LSB], writers[i].instr[RD_LSB-1:0]};

    assign live    = writers[i].valid && writers[i].regWrite && (wrDest[i] != '0);
    assign matchRs = idUseRs && (srcRs == wrDest[i]);
    assign matchRt = idUseRt && (srcRt == wrDest[i]);
    assign wrHit[i] = STALL_EN && live && (matchRs || matchRt);

    always_comb begin
      // R5: a hit is never against register 0
      if (!$isunknown({wrHit[i], wrDest[i]}))
        a_r5_no_zero_dep: assert (!(wrHit[i] && wrDest[i] == '0))
          else $error("register 0 produced a dependence");
    end
  end

  assign strobes.rawHit   = idValid && (|wrHit);
  assign strobes.portBusy = memValid && memAccess;
  assign strobes.redirect = exValid && exBranchTaken;

  always_comb begin
    // R7: an invalid decode stage never stalls
    if (!$isunknown({idValid, strobes.rawHit}))
      a_r7_idle_id: assert (idValid || !strobes.rawHit)
        else $error("stall with empty decode stage");
  end
endmodule

// File: rtl/hazard_control.sv
module hazard_control
  import hazard_pkg::*;
(
  input  hazardStrobes_t strobes,
  output stageCtl_t      ctl
);
  logic holdDecode, blockFetch;

  // A taken branch squashes the decode instruction, so its stalls are moot.
  assign holdDecode = strobes.rawHit && !strobes.redirect;
  assign blockFetch = strobes.portBusy && !strobes.redirect && !holdDecode;

  always_comb begin
    ctl.pcRedirect = strobes.redirect;
    ctl.pcWrite    = strobes.redirect || !(holdDecode || strobes.portBusy);
    ctl.ifIdWrite  = !holdDecode;
    ctl.ifIdClear  = strobes.redirect || blockFetch;
    ctl.idExWrite  = 1'b1;
    ctl.idExClear  = strobes.redirect || holdDecode;
    ctl.exMemWrite = 1'b1;
    ctl.exMemClear = 1'b0;
    ctl.memWbWrite = 1'b1;
    ctl.memWbClear = 1'b0;
  end

  always_comb begin
    if (!$isunknown({strobes, ctl})) begin
      // R10: redirect empties both younger registers and loads the PC
      a_r10_branch_flush: assert (!strobes.redirect ||
                                  (ctl.pcWrite && ctl.ifIdClear && ctl.idExClear))
        else $error("taken branch not flushed");
      // R2: RAW stall holds PC and IF/ID and bubbles ID/EX
      a_r2_raw_hold: assert (!(strobes.rawHit && !strobes.redirect) ||
                             (!ctl.pcWrite && !ctl.ifIdWrite && !ctl.ifIdClear && ctl.idExClear))
        else $error("RAW stall malformed");
      // R8: busy port stops the fetch
      a_r8_port_block: assert (!(strobes.portBusy && !strobes.redirect) || !ctl.pcWrite)
        else $error("fetch during data access");
      // R11: older stages always advance
      a_r11_older_move: assert (ctl.exMemWrite && ctl.memWbWrite &&
                                !ctl.exMemClear && !ctl.memWbClear)
        else $error("older stage held");
    end
  end
endmodule

// File: rtl/pipe_hazard_unit.sv
module pipe_hazard_unit
  import hazard_pkg::*;
#(
  parameter bit SPLIT_RF = 1'b1
) (
  input  logic               idValid,
  input  logic [INSTR_W-1:0] idInstr,
  input  logic               idUseRs,
  input  logic               idUseRt,
  input  logic               exValid,
  input  logic [INSTR_W-1:0] exInstr,
  input  logic               exRegWrite,
  input  logic               exDestRd,
  input  logic               exBranchTaken,
  input  logic               memValid,
  input  logic [INSTR_W-1:0] memInstr,
  input  logic               memRegWrite,
  input  logic               memDestRd,
  input  logic               memAccess,
  input  logic               wbValid,
  input  logic [INSTR_W-1:0] wbInstr,
  input  logic               wbRegWrite,
  input  logic               wbDestRd,
  output logic               pcWrite,
  output logic               pcRedirect,
  output logic               ifIdWrite,
  output logic               ifIdClear,
  output logic               idExWrite,
  output logic               idExClear,
  output logic               exMemWrite,
  output logic               exMemClear,
  output logic               memWbWrite,
  output logic               memWbClear
);
  localparam int unsigned NUM_WR = 3;

  writerDesc_t [NUM_WR-1:0] writers;
  hazardStrobes_t           strobes;
  stageCtl_t                ctl;

  assign writers[0] = '{valid: exValid,  instr: exInstr,  regWrite: exRegWrite,  destRd: exDestRd};
  assign writers[1] = '{valid: memValid, instr: memInstr, regWrite: memRegWrite, destRd: memDestRd};
  assign writers[2] = '{valid: wbValid,  instr: wbInstr,  regWrite: wbRegWrite,  destRd: wbDestRd};

  hazard_datapath #(.SPLIT_RF(SPLIT_RF), .NUM_WR(NUM_WR)) u_datapath (
    .idValid      (idValid),
    .idInstr      (idInstr),
    .idUseRs      (idUseRs),
    .idUseRt      (idUseRt),
    .writers      (writers),
    .exValid      (exValid),
    .exBranchTaken(exBranchTaken),
    .memValid     (memValid),
    .memAccess    (memAccess),
    .strobes      (strobes)
  );

  hazard_control u_control (
    .strobes(strobes),
    .ctl    (ctl)
  );

  assign pcWrite    = ctl.pcWrite;
  assign pcRedirect = ctl.pcRedirect;
  assign ifIdWrite  = ctl.ifIdWrite;
  assign ifIdClear  = ctl.ifIdClear;
  assign idExWrite  = ctl.idExWrite;
  assign idExClear  = ctl.idExClear;
  assign exMemWrite = ctl.exMemWrite;
  assign exMemClear = ctl.exMemClear;
  assign memWbWrite = ctl.memWbWrite;
  assign memWbClear = ctl.memWbClear;
endmodule

// File: tb/pipe_hazard_unit_tb.sv
module pipe_hazard_unit_tb;
  typedef struct packed {
    logic idV; logic [31:0] idI; logic idRs; logic idRt;
    logic exV; logic [31:0] exI; logic exRw; logic exRd; logic exBr;
    logic mV;  logic [31:0] mI;  logic mRw;  logic mRd;  logic mAcc;
    logic wV;  logic [31:0] wI;  logic wRw;  logic wRd;
    logic [9:0] exp; logic [3:0] req;
  } vec_t;

  // Output order: pcWrite pcRedirect ifIdWrite ifIdClear idExWrite idExClear
  //               exMemWrite exMemClear memWbWrite memWbClear
  localparam logic [9:0] RUN  = 10'b1010101010;
  localparam logic [9:0] HOLD = 10'b0000111010;
  localparam logic [9:0] PORT = 10'b0011101010;
  localparam logic [9:0] BRAN = 10'b1111111010;

  function automatic logic [31:0] mk(input int rs, input int rt, input int rd);
    return {6'h0, rs[4:0], rt[4:0], rd[4:0], 11'h0};
  endfunction

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    // R1 all empty
    '{1'b0,32'h0,1'b0,1'b0, 1'b0,32'h0,1'b0,1'b0,1'b0, 1'b0,32'h0,1'b0,1'b0,1'b0, 1'b0,32'h0,1'b0,1'b0, RUN,4'd1},
    // R2 rs against EX rd
    '{1'b1,mk(1,2,3),1'b1,1'b1, 1'b1,mk(0,0,1),1'b1,1'b1,1'b0, 1'b0,32'h0,1'b0,1'b0,1'b0, 1'b0,32'h0,1'b0,1'b0, HOLD,4'd2},
    // R2 rt against EX rd
    '{1'b1,mk(1,2,3),1'b1,1'b1, 1'b1,mk(0,0,2),1'b1,1'b1,1'b0, 1'b0,32'h0,1'b0,1'b0,1'b0, 1'b0,32'h0,1'b0,1'b0, HOLD,4'd2},
    // R3 MEM writer
    '{1'b1,mk(1,2,3),1'b1,1'b1, 1'b0,32'h0,1'b0,1'b0,1'b0, 1'b1,mk(0,0,1),1'b1,1'b1,1'b0, 1'b0,32'h0,1'b0,1'b0, HOLD,4'd3},
    // R4 rt-destination matches
    '{1'b1,mk(1,2,3),1'b1,1'b1, 1'b1,mk(4,1,9),1'b1,1'b0,1'b0, 1'b0,32'h0,1'b0,1'b0,1'b0, 1'b0,32'h0,1'b0,1'b0, HOLD,4'd4},
    // R4 rd-destination does not match
    '{1'b1,mk(1,2,3),1'b1,1'b1, 1'b1,mk(4,1,9),1'b1,1'b1,1'b0, 1'b0,32'h0,1'b0,1'b0,1'b0, 1'b0,32'h0,1'b0,1'b0, RUN,4'd4},
    // R5 register 0
    '{1'b1,mk(0,0,3),1'b1,1'b1, 1'b1,mk(0,0,0),1'b1,1'b1,1'b0, 1'b1,mk(0,0,0),1'b1,1'b0,1'b0, 1'b0,32'h0,1'b0,1'b0, RUN,4'd5},
    // R6 WB writer, split register file
    '{1'b1,mk(1,2,3),1'b1,1'b1, 1'b0,32'h0,1'b0,1'b0,1'b0, 1'b0,32'h0,1'b0,1'b0,1'b0, 1'b1,mk(0,0,1),1'b1,1'b1, RUN,4'd6},
    // R7 unused source
    '{1'b1,mk(1,2,3),1'b0,1'b1, 1'b1,mk(0,0,1),1'b1,1'b1,1'b0, 1'b0,32'h0,1'b0,1'b0,1'b0, 1'b0,32'h0,1'b0,1'b0, RUN,4'd7},
    // R7 writer without regWrite
    '{1'b1,mk(1,2,3),1'b1,1'b1, 1'b1,mk(0,0,1),1'b0,1'b1,1'b0, 1'b0,32'h0,1'b0,1'b0,1'b0, 1'b0,32'h0,1'b0,1'b0, RUN,4'd7},
    // R7 invalid decode stage
    '{1'b0,mk(1,2,3),1'b1,1'b1, 1'b1,mk(0,0,1),1'b1,1'b1,1'b0, 1'b0,32'h0,1'b0,1'b0,1'b0, 1'b0,32'h0,1'b0,1'b0, RUN,4'd7},
    // R8 store in MEM
    '{1'b1,mk(1,2,3),1'b1,1'b1, 1'b0,32'h0,1'b0,1'b0,1'b0, 1'b1,mk(5,1,0),1'b0,1'b0,1'b1, 1'b0,32'h0,1'b0,1'b0, PORT,4'd8},
    // R9 load in MEM writing rt=1 read by decode
    '{1'b1,mk(1,2,3),1'b1,1'b1, 1'b0,32'h0,1'b0,1'b0,1'b0, 1'b1,mk(5,1,0),1'b1,1'b0,1'b1, 1'b0,32'h0,1'b0,1'b0, HOLD,4'd9},
    // R10 branch with busy port
    '{1'b1,mk(1,2,3),1'b1,1'b1, 1'b1,mk(0,0,0),1'b0,1'b0,1'b1, 1'b1,mk(5,7,0),1'b1,1'b0,1'b1, 1'b0,32'h0,1'b0,1'b0, BRAN,4'd10},
    // R10 branch with RAW from MEM
    '{1'b1,mk(1,2,3),1'b1,1'b1, 1'b1,mk(0,0,0),1'b0,1'b0,1'b1, 1'b1,mk(0,0,2),1'b1,1'b1,1'b0, 1'b0,32'h0,1'b0,1'b0, BRAN,4'd10}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic idValid, idUseRs, idUseRt, exValid, exRegWrite, exDestRd, exBranchTaken;
  logic memValid, memRegWrite, memDestRd, memAccess, wbValid, wbRegWrite, wbDestRd;
  logic [31:0] idInstr, exInstr, memInstr, wbInstr;
  logic [9:0] got, gotNs;

  pipe_hazard_unit u_dut (
    .idValid, .idInstr, .idUseRs, .idUseRt,
    .exValid, .exInstr, .exRegWrite, .exDestRd, .exBranchTaken,
    .memValid, .memInstr, .memRegWrite, .memDestRd, .memAccess,
    .wbValid, .wbInstr, .wbRegWrite, .wbDestRd,
    .pcWrite(got[9]), .pcRedirect(got[8]), .ifIdWrite(got[7]), .ifIdClear(got[6]),
    .idExWrite(got[5]), .idExClear(got[4]), .exMemWrite(got[3]), .exMemClear(got[2]),
    .memWbWrite(got[1]), .memWbClear(got[0])
  );

  pipe_hazard_unit #(.SPLIT_RF(1'b0)) u_dutNoSplit (
    .idValid, .idInstr, .idUseRs, .idUseRt,
    .exValid, .exInstr, .exRegWrite, .exDestRd, .exBranchTaken,
    .memValid, .memInstr, .memRegWrite, .memDestRd, .memAccess,
    .wbValid, .wbInstr, .wbRegWrite, .wbDestRd,
    .pcWrite(gotNs[9]), .pcRedirect(gotNs[8]), .ifIdWrite(gotNs[7]), .ifIdClear(gotNs[6]),
    .idExWrite(gotNs[5]), .idExClear(gotNs[4]), .exMemWrite(gotNs[3]), .exMemClear(gotNs[2]),
    .memWbWrite(gotNs[1]), .memWbClear(gotNs[0])
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic apply(input vec_t v);
    @(posedge clk);
    idValid = v.idV; idInstr = v.idI; idUseRs = v.idRs; idUseRt = v.idRt;
    exValid = v.exV; exInstr = v.exI; exRegWrite = v.exRw; exDestRd = v.exRd; exBranchTaken = v.exBr;
    memValid = v.mV; memInstr = v.mI; memRegWrite = v.mRw; memDestRd = v.mRd; memAccess = v.mAcc;
    wbValid = v.wV; wbInstr = v.wI; wbRegWrite = v.wRw; wbDestRd = v.wRd;
    @(negedge clk);
  endtask

  task automatic check(input logic [9:0] act, input logic [9:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  initial begin
    vec_t v;
    v = VECS[0];
    idValid = 0; idInstr = 0; idUseRs = 0; idUseRt = 0;
    exValid = 0; exInstr = 0; exRegWrite = 0; exDestRd = 0; exBranchTaken = 0;
    memValid = 0; memInstr = 0; memRegWrite = 0; memDestRd = 0; memAccess = 0;
    wbValid = 0; wbInstr = 0; wbRegWrite = 0; wbDestRd = 0;
    // R1 idle state after start-up
    apply(VECS[0]);
    check(got, RUN, "R1 idle");
    check({got[3:0]}, 4'b1010, "R11 older stages advance");

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      check(got, VECS[i].exp, $sformatf("R%0d vector %0d", VECS[i].req, i));
    end

    // R6 writeback writer stalls only without the split register file
    apply(VECS[7]);
    check(got, RUN, "R6 split");
    check(gotNs, HOLD, "R6 no split");

    // R2 and R5: exhaustive sweep of rs against an EX rd
    for (int s = 0; s < 32; s++) begin
      for (int d = 0; d < 32; d++) begin
        v = VECS[0];
        v.idV = 1; v.idI = mk(s, 31 - s, 0); v.idRs = 1; v.idRt = 0;
        v.exV = 1; v.exI = mk(0, 0, d); v.exRw = 1; v.exRd = 1;
        apply(v);
        check(got, (d != 0 && d == s) ? HOLD : RUN, $sformatf("R2/R5 sweep rs=%0d rd=%0d", s, d));
      end
    end

    // R11 during every conflict
    apply(VECS[13]);
    check(got[3:0], 4'b1010, "R11 during branch");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule